// File: doc/BRIEF.md
# Flat request aperture router

This block steers each flat vector memory request to one of three targets. Requests that land in the shared window go to on-chip shared memory. Requests that land in the private window go to a per-work-item region of hidden backing memory. Everything else goes to global memory. The router works out the first and last byte of the payload and finds which window each byte falls in. A request is issued only when both bytes resolve to the same legal region.

A request is refused and flagged as a memory violation in two cases: it touches the unused hole of the 64-bit address space, or its payload crosses from one region into another. A violation carries no destination, so the trap logic can act on it. Global addresses leave the block untouched, because translation happens downstream.

Two pointer modes are supported. In 64-bit mode each window is a base/limit pair programmed in 64 KB units and placed inside the address hole. In 32-bit mode only the low 32 bits of the pointer matter. Each window is then a single 64 KB page, and a page number of zero switches that window off. The result appears one clock after the request, together with the request's tag.

Top module: `flat_aperture_router`

## Requirements
- R1: A response appears exactly one cycle after a request: `rsp_valid` is set and `rsp_tag` equals the request's tag. A cycle with no request gives `rsp_valid`=0, `rsp_dest`=0 and `rsp_viol`=0, and reset clears all three.
- R2: In 64-bit mode (`req_mode32`=0), a window spans `{base_pg,16'h0000}` through `{limit_pg,16'hFFFF}`, and both ends count as inside. The windows never overlap.
- R3: When the first and last bytes are both in the shared window, `rsp_dest`=2 and `rsp_addr` is the start address minus the window's first byte.
- R4: When the first and last bytes are both in the private window, `rsp_dest`=3 and `rsp_addr` = `hid_base` + `req_tid`×`hid_stride` + (start − private window's first byte), modulo 2^AW.
- R5: When both bytes are in global space, `rsp_dest`=1 and `rsp_addr` is the start address unchanged (in 32-bit mode, the low 32 bits zero-extended).
- R6: In 64-bit mode, a byte outside both windows whose bits [63:47] are neither all zeros nor all ones lies in the hole. A request whose first byte is in the hole raises a violation.
- R7: The last byte is start + `req_size` − 1, with `req_size` one of 1, 2, 4, 8 or 16, wrapping at 2^64 in 64-bit mode and at 2^32 in 32-bit mode. When the first and last bytes fall in different regions, the request raises a violation.
- R8: A violation response has `rsp_viol`=1, `rsp_dest`=0 and `rsp_addr`=0. It lasts only for that one response.
- R9: In 32-bit mode, bits [63:32] of the address are ignored and each window is the 64 KB page whose number is bits [15:0] of its base field, with limit fields ignored. A shared hit's address is the low 16 bits of the start address; a private hit's offset is also the low 16 bits.
- R10: In 32-bit mode there is no hole, and a window whose page number is zero is disabled. With both windows disabled, every request goes to global memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Start byte address |
| req_size | input | 5 | Payload bytes: 1, 2, 4, 8 or 16 |
| req_tid | input | TIDW | Work-item id |
| req_tag | input | TAGW | Request tag, returned with the response |
| req_mode32 | input | 1 | 1 = 32-bit pointers, 0 = 64-bit pointers |
| shr_base_pg | input | AW-16 | Shared window first 64 KB page |
| shr_limit_pg | input | AW-16 | Shared window last 64 KB page (64-bit mode) |
| prv_base_pg | input | AW-16 | Private window first 64 KB page |
| prv_limit_pg | input | AW-16 | Private window last 64 KB page (64-bit mode) |
| hid_base | input | AW | Hidden private memory base address |
| hid_stride | input | STRW | Hidden private bytes per work-item |
| rsp_valid | output | 1 | Response present |
| rsp_tag | output | TAGW | Tag of the answered request |
| rsp_dest | output | 2 | 0 none, 1 global, 2 shared, 3 private |
| rsp_addr | output | AW | Routed, rebased or expanded address |
| rsp_viol | output | 1 | Memory violation |

## Verification
The bench builds the router with its defaults: AW=64, TIDW=8, STRW=32 and TAGW=4. At these values the full canonical split at bit 47 is in range, as are 4 GB windows placed in the hole and work-item ids up to 255. The same values reach 32-bit strides, where the private expansion can carry into the upper address bits. Random 32-bit-mode traffic redraws the page numbers for each request, zero included. Pages are drawn from disjoint halves of the 16-bit space, so that both the disabled-window case and the page-edge straddle come up often.

// File: rtl/flat_aperture_router.sv
module flat_aperture_router #(
  parameter int AW   = 64,
  parameter int VAW  = 48,
  parameter int TIDW = 8,
  parameter int STRW = 32,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [4:0]      req_size,
  input  logic [TIDW-1:0] req_tid,
  input  logic [TAGW-1:0] req_tag,
  input  logic            req_mode32,
  input  logic [AW-17:0]  shr_base_pg,
  input  logic [AW-17:0]  shr_limit_pg,
  input  logic [AW-17:0]  prv_base_pg,
  input  logic [AW-17:0]  prv_limit_pg,
  input  logic [AW-1:0]   hid_base,
  input  logic [STRW-1:0] hid_stride,
  output logic            rsp_valid,
  output logic [TAGW-1:0] rsp_tag,
  output logic [1:0]      rsp_dest,
  output logic [AW-1:0]   rsp_addr,
  output logic            rsp_viol
);

  localparam int HB = VAW - 1;
  localparam int HW = AW - HB;

  localparam logic [1:0] RG_GLOBAL = 2'd0;
  localparam logic [1:0] RG_SHARED = 2'd1;
  localparam logic [1:0] RG_PRIV   = 2'd2;
  localparam logic [1:0] RG_HOLE   = 2'd3;

  localparam logic [1:0] D_NONE   = 2'd0;
  localparam logic [1:0] D_GLOBAL = 2'd1;
  localparam logic [1:0] D_SHARED = 2'd2;
  localparam logic [1:0] D_PRIV   = 2'd3;

  function automatic logic [1:0] region64(
    input logic [AW-1:0] x,
    input logic [AW-1:0] s_lo, input logic [AW-1:0] s_hi,
    input logic [AW-1:0] p_lo, input logic [AW-1:0] p_hi);
    logic [HW-1:0] top;
    top = x[AW-1:HB];
    if (x >= s_lo && x <= s_hi)               return RG_SHARED;
    if (x >= p_lo && x <= p_hi)               return RG_PRIV;
    if (top != {HW{1'b0}} && top != {HW{1'b1}}) return RG_HOLE;
    return RG_GLOBAL;
  endfunction

  function automatic logic [1:0] region32(
    input logic [31:0] x, input logic [15:0] spg, input logic [15:0] ppg);
    if (spg != 16'h0 && x[31:16] == spg) return RG_SHARED;
    if (ppg != 16'h0 && x[31:16] == ppg) return RG_PRIV;
    return RG_GLOBAL;
  endfunction

  logic [AW-1:0] s_lo, s_hi, p_lo, p_hi, last64;
  logic [31:0]   a32, last32;
  logic [1:0]    rg_first, rg_last;
  logic          viol;
  logic [AW-1:0] sh_off, pr_off, glob_addr, priv_addr;
  logic [1:0]    dest_n;
  logic [AW-1:0] addr_n;

  assign s_lo   = {shr_base_pg, 16'h0000};
  assign s_hi   = {shr_limit_pg, 16'hFFFF};
  assign p_lo   = {prv_base_pg, 16'h0000};
  assign p_hi   = {prv_limit_pg, 16'hFFFF};

  assign last64 = req_addr + AW'(req_size) - AW'(1);
  assign a32    = req_addr[31:0];
  assign last32 = a32 + 32'(req_size) - 32'd1;

  assign rg_first = req_mode32
    ? region32(a32, shr_base_pg[15:0], prv_base_pg[15:0])
    : region64(req_addr, s_lo, s_hi, p_lo, p_hi);
  assign rg_last = req_mode32
    ? region32(last32, shr_base_pg[15:0], prv_base_pg[15:0])
    : region64(last64, s_lo, s_hi, p_lo, p_hi);

  assign viol = (rg_first != rg_last) || (rg_first == RG_HOLE);

  assign sh_off    = req_mode32 ? AW'(a32[15:0]) : req_addr - s_lo;
  assign pr_off    = req_mode32 ? AW'(a32[15:0]) : req_addr - p_lo;
  assign glob_addr = req_mode32 ? AW'(a32) : req_addr;
  assign priv_addr = hid_base + AW'(req_tid) * AW'(hid_stride) + pr_off;

  always_comb begin
    dest_n = D_NONE;
    addr_n = '0;
    if (!viol) begin
      unique case (rg_first)
        RG_SHARED: begin dest_n = D_SHARED; addr_n = sh_off;    end
        RG_PRIV:   begin dest_n = D_PRIV;   addr_n = priv_addr; end
        RG_GLOBAL: begin dest_n = D_GLOBAL; addr_n = glob_addr; end
        default:   begin dest_n = D_NONE;   addr_n = '0;        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_dest  <= D_NONE;
      rsp_addr  <= '0;
      rsp_viol  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_tag   <= req_valid ? req_tag : '0;
      rsp_dest  <= req_valid ? dest_n : D_NONE;
      rsp_addr  <= req_valid ? addr_n : '0;
      rsp_viol  <= req_valid & viol;
    end
  end

endmodule

// File: rtl/flat_aperture_router_chk.sv
module flat_aperture_router_chk #(
  parameter int AW   = 64,
  parameter int TAGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [TAGW-1:0] req_tag,
  input logic            req_mode32,
  input logic [AW-17:0]  shr_base_pg,
  input logic [AW-17:0]  prv_base_pg,
  input logic            rsp_valid,
  input logic [TAGW-1:0] rsp_tag,
  input logic [1:0]      rsp_dest,
  input logic [AW-1:0]   rsp_addr,
  input logic            rsp_viol
);

  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && rsp_tag == $past(req_tag)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && rsp_dest == 2'd0 && !rsp_viol); // R1

  AST_VIOL_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_viol |-> rsp_valid && rsp_dest == 2'd0 && rsp_addr == '0); // R8

  AST_SHARED32_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode32) |=> (rsp_dest != 2'd2 || rsp_addr[AW-1:16] == '0)); // R9

  AST_DISABLED32_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode32 && shr_base_pg[15:0] == 16'h0 && prv_base_pg[15:0] == 16'h0)
      |=> rsp_dest == 2'd1 && !rsp_viol); // R10

endmodule

bind flat_aperture_router flat_aperture_router_chk #(.AW(AW), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
  .req_mode32(req_mode32), .shr_base_pg(shr_base_pg), .prv_base_pg(prv_base_pg),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_dest(rsp_dest),
  .rsp_addr(rsp_addr), .rsp_viol(rsp_viol)
);

// File: tb/flat_aperture_router_tb.sv
`timescale 1ns/1ps
module flat_aperture_router_tb;
  localparam int AW = 64, PW = 48, TIDW = 8, STRW = 32, TAGW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [4:0] req_size = 5'd1;
  logic [TIDW-1:0] req_tid = '0;
  logic [TAGW-1:0] req_tag = '0;
  logic req_mode32 = 1'b0;
  logic [PW-1:0] shr_base_pg, shr_limit_pg, prv_base_pg, prv_limit_pg;
  logic [AW-1:0] hid_base;
  logic [STRW-1:0] hid_stride;
  logic rsp_valid, rsp_viol;
  logic [TAGW-1:0] rsp_tag;
  logic [1:0] rsp_dest;
  logic [AW-1:0] rsp_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [TAGW-1:0] tag_ctr = '0;

  localparam logic [PW-1:0] S64_B = 48'h0001_0000_0000, S64_L = 48'h0001_0000_FFFF;
  localparam logic [PW-1:0] P64_B = 48'h0002_0000_0000, P64_L = 48'h0002_0000_FFFF;

  always #2.5 clk = ~clk;

  flat_aperture_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_tid(req_tid), .req_tag(req_tag), .req_mode32(req_mode32),
    .shr_base_pg(shr_base_pg), .shr_limit_pg(shr_limit_pg),
    .prv_base_pg(prv_base_pg), .prv_limit_pg(prv_limit_pg),
    .hid_base(hid_base), .hid_stride(hid_stride),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_dest(rsp_dest),
    .rsp_addr(rsp_addr), .rsp_viol(rsp_viol));

  function automatic logic [1:0] m_reg64(input logic [63:0] x);
    if (x >= {shr_base_pg, 16'h0} && x <= {shr_limit_pg, 16'hFFFF}) return 2'd1;
    if (x >= {prv_base_pg, 16'h0} && x <= {prv_limit_pg, 16'hFFFF}) return 2'd2;
    if (x[63:47] != 17'h0 && x[63:47] != 17'h1FFFF) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [1:0] m_reg32(input logic [31:0] x);
    if (shr_base_pg[15:0] != 0 && x[31:16] == shr_base_pg[15:0]) return 2'd1;
    if (prv_base_pg[15:0] != 0 && x[31:16] == prv_base_pg[15:0]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic model(input logic [63:0] a, input logic [4:0] sz, input logic [TIDW-1:0] tid,
                       input logic m32, output logic [1:0] ed, output logic [63:0] ea, output logic ev);
    logic [1:0] f, l;
    logic [63:0] off;
    if (m32) begin
      f = m_reg32(a[31:0]);
      l = m_reg32(a[31:0] + 32'(sz) - 32'd1);
    end else begin
      f = m_reg64(a);
      l = m_reg64(a + 64'(sz) - 64'd1);
    end
    ev = (f != l) || f == 2'd3;
    ed = 2'd0; ea = '0;
    if (!ev) begin
      case (f)
        2'd0: begin ed = 2'd1; ea = m32 ? {32'h0, a[31:0]} : a; end
        2'd1: begin ed = 2'd2; ea = m32 ? {48'h0, a[15:0]} : a - {shr_base_pg, 16'h0}; end
        default: begin
          off = m32 ? {48'h0, a[15:0]} : a - {prv_base_pg, 16'h0};
          ed = 2'd3; ea = hid_base + 64'(tid) * 64'(hid_stride) + off;
        end
      endcase
    end
  endtask

  task automatic set64();
    shr_base_pg = S64_B; shr_limit_pg = S64_L; prv_base_pg = P64_B; prv_limit_pg = P64_L;
  endtask

  task automatic set32(input logic [15:0] sp, input logic [15:0] pp);
    shr_base_pg = {32'($urandom), sp}; shr_limit_pg = {16'($urandom), 32'($urandom)};
    prv_base_pg = {32'($urandom), pp}; prv_limit_pg = {16'($urandom), 32'($urandom)};
  endtask

  task automatic send(input string rq, input logic [63:0] a, input logic [4:0] sz,
                      input logic [TIDW-1:0] tid, input logic m32);
    logic [1:0] ed; logic [63:0] ea; logic ev; logic [TAGW-1:0] et;
    @(negedge clk);
    req_addr = a; req_size = sz; req_tid = tid; req_mode32 = m32;
    et = tag_ctr; req_tag = tag_ctr; tag_ctr = tag_ctr + 1'b1; req_valid = 1'b1;
    model(a, sz, tid, m32, ed, ea, ev);
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_dest !== ed || rsp_addr !== ea || rsp_viol !== ev || rsp_tag !== et) begin
      n_bad++;
      $display("FAIL %s: got v=%0b d=%0d a=%h viol=%0b tag=%0d, expected v=1 d=%0d a=%h viol=%0b tag=%0d",
               rq, rsp_valid, rsp_dest, rsp_addr, rsp_viol, rsp_tag, ed, ea, ev, et);
    end
  endtask

  task automatic check_idle(input string rq);
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_dest !== 2'd0 || rsp_viol !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got v=%0b d=%0d viol=%0b, expected v=0 d=0 viol=0", rq, rsp_valid, rsp_dest, rsp_viol);
    end
  endtask

  function automatic logic [4:0] rsize();
    return 5'(1 << ($urandom % 5));
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    logic [15:0] sp, pp;
    void'($urandom(32'h5EED));
    set64();
    hid_base = 64'h0000_0040_0000_0000; hid_stride = 32'h0001_0000;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1'b1;
    check_idle("R1 idle cycle");

    send("R2 R3 shared first byte", 64'h0001_0000_0000_0000, 5'd4, 8'd0, 1'b0);
    send("R2 R3 shared last byte", 64'h0001_0000_FFFF_FFFF, 5'd1, 8'd0, 1'b0);
    send("R7 shared straddles into hole", 64'h0001_0000_FFFF_FFFC, 5'd8, 8'd0, 1'b0);
    send("R4 private expand", 64'h0002_0000_0000_1230, 5'd16, 8'd37, 1'b0);
    send("R8 follow-up clean", 64'h0000_0000_0000_1000, 5'd4, 8'd0, 1'b0);
    send("R6 hole miss", 64'h0005_0000_0000_0000, 5'd4, 8'd0, 1'b0);
    send("R5 global high canonical", 64'hFFFF_8000_0000_0010, 5'd8, 8'd3, 1'b0);
    send("R7 global into hole", 64'h0000_7FFF_FFFF_FFF8, 5'd16, 8'd0, 1'b0);
    send("R7 wrap at 2^64", 64'hFFFF_FFFF_FFFF_FFF8, 5'd16, 8'd0, 1'b0);
    hid_stride = 32'hFFFF_FFF0;
    send("R4 stride carry", 64'h0002_0000_FFFF_FF00, 5'd2, 8'd255, 1'b0);
    hid_stride = 32'h0001_0000;
    check_idle("R8 violation lasts one response");

    set32(16'h0000, 16'h0000);
    send("R10 both disabled", 64'h1234_5678_0000_0004, 5'd4, 8'd1, 1'b1);
    set32(16'h0010, 16'h8020);
    send("R9 shared page hit, upper ignored", 64'hDEAD_BEEF_0010_ABC0, 5'd8, 8'd0, 1'b1);
    send("R9 private page hit", 64'h0000_0000_8020_0100, 5'd4, 8'd9, 1'b1);
    send("R7 32-bit page straddle", 64'h0000_0000_0010_FFFE, 5'd4, 8'd0, 1'b1);
    send("R7 32-bit wrap global", 64'hAAAA_0000_FFFF_FFF8, 5'd16, 8'd0, 1'b1);
    send("R10 no hole in 32-bit", 64'h0000_0000_7FFF_0000, 5'd4, 8'd0, 1'b1);

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 4 == 0) begin
        sp = ($urandom % 3 == 0) ? 16'h0 : 16'(($urandom % 16'h7FFF) + 1);
        pp = ($urandom % 3 == 0) ? 16'h0 : (16'h8000 | 16'($urandom));
        set32(sp, pp);
        case ($urandom % 4)
          0: a = {32'($urandom), sp, 16'($urandom)};
          1: a = {32'($urandom), pp, 16'($urandom)};
          2: a = {32'($urandom), sp - 16'd1, 16'hFFF0 | 16'($urandom % 16)};
          default: a = {32'($urandom), 32'($urandom)};
        endcase
        send("R9 R10 random 32-bit", a, rsize(), 8'($urandom), 1'b1);
      end else begin
        set64();
        case ($urandom % 6)
          0: a = {17'h0, 15'($urandom), 32'($urandom)};
          1: a = {17'h1FFFF, 15'($urandom), 32'($urandom)};
          2: a = ($urandom % 2) ? {S64_B, 16'h0} + 64'($urandom)
                                : {S64_L, 16'hFFF0} + 64'($urandom % 16);
          3: a = ($urandom % 2) ? {P64_B, 16'h0} + 64'($urandom)
                                : {P64_L, 16'hFFF0} + 64'($urandom % 16);
          4: a = {16'h0005, 16'($urandom), 32'($urandom)};
          default: a = 64'h0000_7FFF_FFFF_FFF0 + 64'($urandom % 32);
        endcase
        send("R2 R3 R4 R5 R6 R7 random 64-bit", a, rsize(), 8'($urandom), 1'b0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule